// File: doc/BRIEF.md
# 48-bit Compare Timer

This block is a free-running 48-bit up-counter with two 48-bit compare channels and a small interrupt unit. Software reaches it over a simple single-cycle register port with 32-bit data. Because the count is wider than the data bus, every 48-bit quantity is split into a high word (16 bits in bits [15:0]) and a low word (32 bits). Split accesses are made safe in both directions. A load or compare value is written high-then-low and takes effect only on the low-word write. A read of the buffered high word freezes the whole count, so the following low-word read belongs to the same instant.

When the counter is running and equals a channel's committed compare value, that channel's flag is latched. Each flag has an enable bit. The enable bits are changed through separate set and clear registers, where writing 1 acts on a bit and writing 0 leaves it alone. Flags are cleared through their own write-one-to-clear register. The single interrupt output is high while any enabled flag is set.

Top module: `cmp_timer48`

## Requirements
- R1: After reset the counter, the control register, both compare values, all flags and all enables are zero, and `irq` is low.
- R2: While control bit 0 (offset 0x00) is 1, the counter advances by one each cycle. While it is 0, the counter holds its value.
- R3: A write to 0x30 stages bits [15:0] as the high load word. A write to 0x34 sets the counter to {staged high, written word} on the next edge. A load overrides the increment.
- R4: The counter wraps from 0xFFFF_FFFFFFFF to 0.
- R5: Offset 0x28 reads {16'b0, count[47:32]} and offset 0x2C reads count[31:0], both live.
- R6: A read of 0x20 returns {16'b0, count[47:32]} and captures the full count. A later read of 0x24 returns the low 32 bits of that capture, even if the counter has since changed.
- R7: Compare A uses high/low words at 0x10/0x14, and compare B uses 0x18/0x1C. A high-word write is staged and has no visible effect. The low-word write commits {staged high, low}. Reads return the committed value.
- R8: While running, when the count equals a channel's committed value, that channel's flag sets: bit 0 for A, bit 1 for B. Offset 0x44 reads the flags regardless of enables.
- R9: Writing 1 to a bit at 0x48 enables that source, and writing 1 to a bit at 0x4C disables it. Zero bits have no effect. Offset 0x48 reads the enable mask.
- R10: Offset 0x40 reads flags AND enables. `irq` is the OR of those bits.
- R11: Writing 1 to a bit at 0x50 clears that flag. Zero bits have no effect.
- R12: A match and a clear of the same flag in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the capture side effect) |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
The bench places a low-word carry inside a compare match, so a comparator that matches on only the low word fires early and leaves a wrong flag. A load near the top of the range checks the wrap: a counter that saturates or drops the high word would never hit compare B at zero. A clear is timed to land in the same cycle as a match, which exposes a design where the clear wins. The counter is reloaded between a buffered-high and a buffered-low read, so a design that reads the low word live instead of from the capture returns the new value. A staged compare high word is read back before it is committed, which catches a design that updates the comparator half-written.

// File: rtl/t48_pkg.sv
package t48_pkg;
    // Byte offsets of the register window; software decodes these.
    localparam int OFS_CTRL    = 'h00;
    localparam int OFS_CMP0_HI = 'h10;
    localparam int OFS_BUF_HI  = 'h20;
    localparam int OFS_BUF_LO  = 'h24;
    localparam int OFS_RAW_HI  = 'h28;
    localparam int OFS_RAW_LO  = 'h2C;
    localparam int OFS_LD_HI   = 'h30;
    localparam int OFS_LD_LO   = 'h34;
    localparam int OFS_ST_MSK  = 'h40;
    localparam int OFS_ST_RAW  = 'h44;
    localparam int OFS_EN_SET  = 'h48;
    localparam int OFS_EN_CLR  = 'h4C;
    localparam int OFS_FLG_CLR = 'h50;
    localparam int CMP_STRIDE  = 8;

    function automatic int cmp_hi_ofs(input int ch);
        return OFS_CMP0_HI + CMP_STRIDE * ch;
    endfunction

    function automatic int cmp_lo_ofs(input int ch);
        return OFS_CMP0_HI + CMP_STRIDE * ch + 4;
    endfunction
endpackage

// File: rtl/t48_counter.sv
module t48_counter #(
    parameter int CNT_W  = 48,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ld_hi_we,
    input  logic              ld_lo_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);
    localparam int HI_W = CNT_W - DATA_W;

    typedef struct packed {
        logic [HI_W-1:0]  stage;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (ld_hi_we) begin
            ctr_d.stage = wdata[HI_W-1:0];
        end
        if (ld_lo_we) begin
            ctr_d.cnt = {ctr_q.stage, wdata};
        end else if (run) begin
            ctr_d.cnt = ctr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign cnt = ctr_q.cnt;
endmodule

// File: rtl/t48_cmp_chan.sv
module t48_cmp_chan #(
    parameter int CNT_W  = 48,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              run,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              hit
);
    localparam int HI_W = CNT_W - DATA_W;

    typedef struct packed {
        logic [HI_W-1:0]  stage;
        logic [CNT_W-1:0] val;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    always_comb begin
        cmp_d = cmp_q;
        if (hi_we) cmp_d.stage = wdata[HI_W-1:0];
        if (lo_we) cmp_d.val   = {cmp_q.stage, wdata};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end

    assign cmp_val = cmp_q.val;
    assign hit     = run && (cnt == cmp_q.val);
endmodule

// File: rtl/t48_irq.sv
module t48_irq #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] hit,
    input  logic             en_set_we,
    input  logic             en_clr_we,
    input  logic             flg_clr_we,
    input  logic [N_SRC-1:0] wbits,
    output logic [N_SRC-1:0] flag,
    output logic [N_SRC-1:0] en,
    output logic             irq
);
    typedef struct packed {
        logic [N_SRC-1:0] flag;
        logic [N_SRC-1:0] en;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (en_set_we)  irq_d.en   = irq_d.en | wbits;
        if (en_clr_we)  irq_d.en   = irq_d.en & ~wbits;
        if (flg_clr_we) irq_d.flag = irq_d.flag & ~wbits;
        // a match in the same cycle wins over the clear
        irq_d.flag = irq_d.flag | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign flag = irq_q.flag;
    assign en   = irq_q.en;
    assign irq  = |(irq_q.flag & irq_q.en);
endmodule

// File: rtl/cmp_timer48.sv
module cmp_timer48 #(
    parameter int CNT_W  = 48,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int N_CMP  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    import t48_pkg::*;

    localparam int HI_W = CNT_W - DATA_W;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] snap;
    } top_t;

    top_t top_d, top_q;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp_val [N_CMP];
    logic [N_CMP-1:0] hit;
    logic [N_CMP-1:0] flag;
    logic [N_CMP-1:0] en;

    function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    t48_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (top_q.run),
        .ld_hi_we (wr_en && at(addr, OFS_LD_HI)),
        .ld_lo_we (wr_en && at(addr, OFS_LD_LO)),
        .wdata    (wdata),
        .cnt      (cnt)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        t48_cmp_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .hi_we   (wr_en && at(addr, cmp_hi_ofs(g))),
            .lo_we   (wr_en && at(addr, cmp_lo_ofs(g))),
            .wdata   (wdata),
            .cnt     (cnt),
            .run     (top_q.run),
            .cmp_val (cmp_val[g]),
            .hit     (hit[g])
        );
    end

    t48_irq #(.N_SRC(N_CMP)) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .en_set_we  (wr_en && at(addr, OFS_EN_SET)),
        .en_clr_we  (wr_en && at(addr, OFS_EN_CLR)),
        .flg_clr_we (wr_en && at(addr, OFS_FLG_CLR)),
        .wbits      (wdata[N_CMP-1:0]),
        .flag       (flag),
        .en         (en),
        .irq        (irq)
    );

    always_comb begin
        top_d = top_q;
        if (wr_en && at(addr, OFS_CTRL)) top_d.run  = wdata[0];
        if (rd_en && at(addr, OFS_BUF_HI)) top_d.snap = cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        rdata = '0;
        if (at(addr, OFS_CTRL))   rdata[0] = top_q.run;
        if (at(addr, OFS_BUF_HI) || at(addr, OFS_RAW_HI))
            rdata[HI_W-1:0] = cnt[CNT_W-1:DATA_W];
        if (at(addr, OFS_BUF_LO)) rdata = top_q.snap[DATA_W-1:0];
        if (at(addr, OFS_RAW_LO)) rdata = cnt[DATA_W-1:0];
        if (at(addr, OFS_ST_MSK)) rdata[N_CMP-1:0] = flag & en;
        if (at(addr, OFS_ST_RAW)) rdata[N_CMP-1:0] = flag;
        if (at(addr, OFS_EN_SET)) rdata[N_CMP-1:0] = en;
        for (int i = 0; i < N_CMP; i++) begin
            if (at(addr, cmp_hi_ofs(i))) rdata[HI_W-1:0] = cmp_val[i][CNT_W-1:DATA_W];
            if (at(addr, cmp_lo_ofs(i))) rdata = cmp_val[i][DATA_W-1:0];
        end
    end
endmodule

// File: rtl/t48_checker.sv
module t48_checker #(
    parameter int CNT_W  = 48,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int N_CMP  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [CNT_W-1:0]  cnt,
    input logic              run,
    input logic [N_CMP-1:0]  hit,
    input logic [N_CMP-1:0]  flag,
    input logic [N_CMP-1:0]  en
);
    import t48_pkg::*;

    logic ld_lo_wr, fclr_wr, eset_wr, eclr_wr, msk_rd;
    assign ld_lo_wr = wr_en && (addr == ADDR_W'(OFS_LD_LO));
    assign fclr_wr  = wr_en && (addr == ADDR_W'(OFS_FLG_CLR));
    assign eset_wr  = wr_en && (addr == ADDR_W'(OFS_EN_SET));
    assign eclr_wr  = wr_en && (addr == ADDR_W'(OFS_EN_CLR));
    assign msk_rd   = rd_en && (addr == ADDR_W'(OFS_ST_MSK));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_lo_wr) |=> cnt == $past(cnt) + 1'b1);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_lo_wr) |=> $stable(cnt));

    // R3
    load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo_wr |=> cnt[DATA_W-1:0] == $past(wdata));

    // R9
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eset_wr && wdata[0]) |=> en[0]);

    // R9
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eclr_wr && wdata[0]) |=> !en[0]);

    // R10
    masked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msk_rd |-> rdata[N_CMP-1:0] == (flag & en));

    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fclr_wr && wdata[0] && !hit[0]) |=> !flag[0]);

    // R12
    hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> flag[0]);
endmodule

bind cmp_timer48 t48_checker #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_CMP(N_CMP)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .cnt   (cnt),
    .run   (top_q.run),
    .hit   (hit),
    .flag  (flag),
    .en    (en)
);

// File: tb/cmp_timer48_tb_top.sv
`timescale 1ns/1ps
module cmp_timer48_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        irq_probe = 1'b0;
    logic        done = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    cmp_timer48 dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        item_t it;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        it.exp = e; it.tag = t;
        exp_q.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        item_t it;
        @(negedge clk);
        irq_probe = 1'b1;
        it.exp = {31'b0, e}; it.tag = t;
        exp_q.push_back(it);
        @(negedge clk);
        irq_probe = 1'b0;
    endtask

    // monitor: samples mid low phase, away from the rising edge
    always @(negedge clk) begin
        #1;
        if ((rd_en || irq_probe) && exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            act = irq_probe ? {31'b0, irq} : rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, 32'h0, "R1 ctrl");
        rd(8'h2C, 32'h0, "R1 count low");
        rd(8'h14, 32'h0, "R1 compare A low");
        rd(8'h44, 32'h0, "R1 raw flags");
        rd(8'h48, 32'h0, "R1 enables");
        chk_irq(1'b0, "R1 irq");

        // R3 load while stopped, R5 live reads
        wr(8'h30, 32'hFFFF_1234);
        wr(8'h34, 32'hFFFF_FFFE);
        rd(8'h28, 32'h0000_1234, "R5 raw high");
        rd(8'h2C, 32'hFFFF_FFFE, "R3 loaded low");

        // R7 staged compare high is invisible until the low word
        wr(8'h10, 32'h0000_1235);
        rd(8'h10, 32'h0, "R7 staged high not committed");
        wr(8'h14, 32'h0000_0001);
        rd(8'h10, 32'h0000_1235, "R7 committed high");
        rd(8'h14, 32'h0000_0001, "R7 committed low");
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'h0000_0005);
        rd(8'h44, 32'h0, "R8 no match while stopped");

        // R2 run for 12 increments across the low-word carry
        wr(8'h00, 32'h1);
        repeat (10) @(negedge clk);
        wr(8'h00, 32'h0);
        rd(8'h28, 32'h0000_1235, "R2 count high after run");
        rd(8'h2C, 32'h0000_000A, "R2 count low after run");
        rd(8'h44, 32'h1, "R8 compare A flag only");
        rd(8'h40, 32'h0, "R10 masked while disabled");
        chk_irq(1'b0, "R10 irq low while disabled");

        // R9 enables
        wr(8'h48, 32'h0);
        rd(8'h48, 32'h0, "R9 zero write no effect");
        wr(8'h48, 32'h1);
        rd(8'h48, 32'h1, "R9 enable set");
        rd(8'h40, 32'h1, "R10 masked status");
        chk_irq(1'b1, "R10 irq high");

        // R11 flag clear
        wr(8'h50, 32'h0);
        rd(8'h44, 32'h1, "R11 zero clear no effect");
        wr(8'h50, 32'h1);
        rd(8'h44, 32'h0, "R11 flag cleared");
        chk_irq(1'b0, "R11 irq dropped");
        wr(8'h4C, 32'h1);
        rd(8'h48, 32'h0, "R9 enable clear");
        rd(8'h2C, 32'h0000_000A, "R2 held while stopped");

        // R4 wrap, compare B at zero
        wr(8'h30, 32'h0000_FFFF);
        wr(8'h34, 32'hFFFF_FFFE);
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'h0);
        wr(8'h00, 32'h1);
        repeat (1) @(negedge clk);
        wr(8'h00, 32'h0);
        rd(8'h28, 32'h0, "R4 high wrapped");
        rd(8'h2C, 32'h1, "R4 low wrapped");
        rd(8'h44, 32'h2, "R8 compare B flag");
        wr(8'h48, 32'h2);
        rd(8'h40, 32'h2, "R10 masked B");
        chk_irq(1'b1, "R10 irq from B");
        wr(8'h50, 32'h2);
        wr(8'h4C, 32'h2);

        // R12 clear lands in the match cycle
        wr(8'h30, 32'h0);
        wr(8'h34, 32'h0000_0100);
        wr(8'h10, 32'h0);
        wr(8'h14, 32'h0000_0105);
        wr(8'h00, 32'h1);
        repeat (4) @(negedge clk);
        wr(8'h50, 32'h1);
        wr(8'h00, 32'h0);
        rd(8'h44, 32'h1, "R12 match beats clear");
        rd(8'h2C, 32'h0000_0108, "R2 count after R12 run");

        // R6 coherent split read
        rd(8'h20, 32'h0, "R6 buffered high");
        wr(8'h30, 32'h0000_00AB);
        wr(8'h34, 32'h0000_0055);
        rd(8'h24, 32'h0000_0108, "R6 buffered low from capture");
        rd(8'h2C, 32'h0000_0055, "R5 live low after reload");
        rd(8'h20, 32'h0000_00AB, "R6 buffered high new");
        rd(8'h24, 32'h0000_0055, "R6 buffered low new");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule